// File: doc/BRIEF.md
# Vertical-Crosswise 4x4 Unsigned Multiplier

This block multiplies two unsigned 4-bit operands and returns their full 8-bit product. Each operand is cut into a low pair of bits (bits 1:0) and a high pair (bits 3:2). Four small 2x2 multipliers then form every pairing of those halves. Two ripple-carry adder rows, a full-adder cell and a half adder merge the four partial results, each shifted to its proper weight, into the final product. No flat array of partial-product bits is built.

The product can leave the block straight from the adder network. It can also pass through one output register that has a synchronous, active-high reset. The parameter `REG_OUT` picks between the two. Its default is 1, the registered form. A designer drops the block into a datapath that needs a small, exact unsigned product, either with one cycle of latency or with none.

Top module: `vx_mul4`

## Requirements
- R1: For every one of the 256 operand pairs, the product equals op_a × op_b exactly in 8 bits (for example, 0×n = 0 and 15×15 = 225).
- R2: The 2x2 sub-multiplier `vx_mul2` returns the 4-bit product of its two 2-bit inputs for all 16 input pairs. Its bit 0 is a0·b0, and its bit 1 is a1·b0 XOR a0·b1.
- R3: The four partial products are low×low, high×low, low×high and high×high. Here "low" means operand bits 1:0 and "high" means operand bits 3:2.
- R4: Product bits 1:0 are taken unchanged from bits 1:0 of the low×low partial product, so bit 0 equals op_a[0]·op_b[0].
- R5: The carry out of the top half adder is never 1, so no product bit is lost above bit 7.
- R6: With REG_OUT = 1, the product of the operands present at a rising clock edge appears on `prod` after that edge and holds until the next edge.
- R7: With REG_OUT = 1, a high `rst` at a rising edge clears `prod` to 0 for that cycle, whatever the operands are.
- R8: With REG_OUT = 0, `prod` follows the operands with no clock latency, and `rst` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 4 | Unsigned multiplicand |
| op_b | input | 4 | Unsigned multiplier |
| prod | output | 8 | Unsigned product, registered when REG_OUT = 1 |

## Verification
The assertions assume that op_a and op_b are known and steady around each rising clock edge. They also assume that `rst` is held high at the first edge, so the register starts from a defined value. The stimulus changes the operands and `rst` only on falling edges, and it holds reset high from time zero. It sweeps all 256 operand pairs through a registered instance and a combinational instance side by side. Within that sweep, it applies a mid-run reset while the operands are nonzero.

// File: rtl/vx_mul2.sv
module vx_mul2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic v0, x10, x01, v1, k1, k2;

  assign v0  = a[0] & b[0];
  assign x10 = a[1] & b[0];
  assign x01 = a[0] & b[1];
  assign v1  = a[1] & b[1];

  assign k1  = x10 & x01;
  assign k2  = v1 & k1;

  assign p[0] = v0;
  assign p[1] = x10 ^ x01;
  assign p[2] = v1 ^ k1;
  assign p[3] = k2;
endmodule

// File: rtl/vx_mul4.sv
module vx_mul4 #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] op_a,
  input  logic [3:0] op_b,
  output logic [7:0] prod
);
  localparam int HW = 2;
  localparam int OW = 2 * HW;
  localparam int PW = 2 * OW;

  logic [OW-1:0] ll, hl, lh, hh;
  logic [OW-1:0] x, u, y;
  logic [OW:0]   cx, cy;
  logic          p6, c6, p7, c7;
  logic [PW-1:0] comb;

  vx_mul2 u_ll (.a(op_a[HW-1:0]),  .b(op_b[HW-1:0]),  .p(ll));
  vx_mul2 u_hl (.a(op_a[OW-1:HW]), .b(op_b[HW-1:0]),  .p(hl));
  vx_mul2 u_lh (.a(op_a[HW-1:0]),  .b(op_b[OW-1:HW]), .p(lh));
  vx_mul2 u_hh (.a(op_a[OW-1:HW]), .b(op_b[OW-1:HW]), .p(hh));

  assign u     = {hh[HW-1:0], ll[OW-1:HW]};
  assign cx[0] = 1'b0;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < OW; i++) begin : g_rca
    assign x[i]    = hl[i] ^ lh[i] ^ cx[i];
    assign cx[i+1] = (hl[i] & lh[i]) | ((hl[i] ^ lh[i]) & cx[i]);
    assign y[i]    = x[i] ^ u[i] ^ cy[i];
    assign cy[i+1] = (x[i] & u[i]) | ((x[i] ^ u[i]) & cy[i]);
  end

  assign p6 = hh[HW] ^ cx[OW] ^ cy[OW];
  assign c6 = (hh[HW] & cx[OW]) | ((hh[HW] ^ cx[OW]) & cy[OW]);
  assign p7 = hh[HW+1] ^ c6;
  assign c7 = hh[HW+1] & c6;

  assign comb = {p7, p6, y, ll[HW-1:0]};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) prod <= '0;
      else     prod <= comb;
    end

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> prod == PW'({4'b0, $past(op_a)} * {4'b0, $past(op_b)}));
    assert_reset_clear_R7: assert property (@(posedge clk)
      rst |=> prod == '0);
  end else begin : g_comb
    assign prod = comb;

    assert_comb_exact_R8: assert property (@(posedge clk) disable iff (rst)
      prod == PW'({4'b0, op_a} * {4'b0, op_b}));
  end

  assert_exact_R1: assert property (@(posedge clk) disable iff (rst)
    comb == PW'({4'b0, op_a} * {4'b0, op_b}));
  assert_partials_R3: assert property (@(posedge clk) disable iff (rst)
    hl == OW'({2'b0, op_a[3:2]} * {2'b0, op_b[1:0]}) &&
    lh == OW'({2'b0, op_a[1:0]} * {2'b0, op_b[3:2]}) &&
    hh == OW'({2'b0, op_a[3:2]} * {2'b0, op_b[3:2]}));
  assert_low_bits_R4: assert property (@(posedge clk) disable iff (rst)
    comb[0] == (op_a[0] & op_b[0]) && comb[1] == ((op_a[1] & op_b[0]) ^ (op_a[0] & op_b[1])));
  assert_mul2_R2: assert property (@(posedge clk) disable iff (rst)
    ll == OW'({2'b0, op_a[1:0]} * {2'b0, op_b[1:0]}));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    c7 == 1'b0);
endmodule

// File: tb/vx_mul4_tb_top.sv
module vx_mul4_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_a = '0, op_b = '0;
  logic [7:0] prod, prod_c;
  logic [1:0] sa = '0, sb = '0;
  logic [3:0] sp;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] expq[$];

  always #2 clk = ~clk;

  vx_mul4 #(.REG_OUT(1'b1)) dut_i   (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod(prod));
  vx_mul4 #(.REG_OUT(1'b0)) dut_c_i (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod(prod_c));
  vx_mul2 m2_i (.a(sa), .b(sb), .p(sp));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int a, input int b);
    @(negedge clk);
    op_a = 4'(a);
    op_b = 4'(b);
    expq.push_back(8'(a * b));
    #1;
    chk("R8 comb follows", prod_c, 8'(a * b));
    chk("R4 low bits", {6'b0, prod_c[1:0]}, {6'b0, 2'(((a % 4) * (b % 4)) % 4)});
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        logic [7:0] e;
        e = expq.pop_front();
        chk("R1/R6 registered product", prod, e);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 16; i++) begin
      sa = 2'(i / 4);
      sb = 2'(i % 4);
      #1;
      chk("R2 mul2 product", {4'b0, sp}, 8'((i / 4) * (i % 4)));
      chk("R2 mul2 bit1", {7'b0, sp[1]}, {7'b0, sa[1] & sb[0] ^ sa[0] & sb[1]});
    end
    op_a = 4'd9;
    op_b = 4'd7;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset state", prod, 8'd0);
    chk("R8 comb ignores reset", prod_c, 8'd63);
    @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        drive(a, b);
    drive(15, 15);
    drive(0, 15);
    drive(15, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    op_a = 4'd13;
    op_b = 4'd11;
    @(posedge clk);
    #1;
    chk("R7 mid-run reset clears", prod, 8'd0);
    chk("R8 reset no effect on comb", prod_c, 8'd143);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R6 product after reset release", prod, 8'd143);
    @(negedge clk);
    op_a = 4'd2;
    #1;
    chk("R6 holds between edges", prod, 8'd143);
    chk("R8 comb immediate", prod_c, 8'd22);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule